// File: doc/BRIEF.md
# Variable-Length SPI Command Slave

This block is a mode-0 SPI slave that sits behind an oversampling front end. The serial clock, the select and the serial input are synchronised into a faster system clock. Edges of the serial clock are detected there, so the whole block runs on one clock domain. The first byte of every frame sets its length. A byte with its top bit set is a short control command. The block ends that frame after 8 serial clocks and pulses a control strobe carrying the 7-bit command field. A byte with its top bit clear opens a 24-clock register-access frame. In that byte, a 4-bit register address sits in bits 6:3, bit 2 selects read (1) or write (0), and bits 1:0 are ignored.

A write frame delivers a 16-bit word, most significant bit first, after the header byte. The block then presents the word on a one-cycle write strobe together with the address. A read frame puts the address on the register-file read port. At the 8th falling serial clock edge it loads the returned 16-bit value into an output shifter. The value then leaves on the serial output, most significant bit first, changing only after falling edges. While select stays low, frames of either kind may follow each other directly. Raising select drops any partial frame without a strobe and releases the serial output.

Top module: `spi_cmd_slave`

## Requirements
- R1: After reset the output enable is low, the serial output data is 0 and neither strobe is asserted.
- R2: A header byte with bit 7 = 1 ends the frame after 8 serial clocks. The control strobe then pulses for exactly one system clock, with the command output equal to header bits 6:0.
- R3: A header byte with bit 7 = 0 and bit 2 = 0 is a write. After the 24th rising edge the write strobe pulses for exactly one system clock. The write address equals header bits 6:3, and the write data equals the 16 bits that followed the header, first bit as MSB.
- R4: A header byte with bit 7 = 0 and bit 2 = 1 is a read. The read address output equals header bits 6:3. The register value appears on the serial output MSB first, one bit before each of rising edges 9 to 24. No write strobe is issued.
- R5: With select held low, consecutive frames of mixed kinds are each decoded from their own header. Each frame gives the same result as it would alone.
- R6: Raising select before a frame is complete discards that frame without any strobe. The next frame after select falls again starts counting from its first bit.
- R7: The serial output enable is high exactly while the synchronised select is active.
- R8: The serial output data is 0 outside the 16-bit data phase of a read frame. While select is active it changes only following a detected falling edge of the serial clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the master, idles low |
| cs_n | input | 1 | Active-low select from the master |
| mosi | input | 1 | Serial data from the master |
| miso_data | output | 1 | Serial data to the master |
| miso_en | output | 1 | Drive enable for the serial output pad (low = high impedance) |
| rd_addr | output | 4 | Register-file read address |
| rd_data | input | 16 | Register-file read data, combinational from rd_addr |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_addr | output | 4 | Register write address |
| wr_data | output | 16 | Register write data |
| ctl_stb | output | 1 | One-cycle control command strobe |
| ctl_cmd | output | 7 | Control command field |

## Verification
The assertions assume that the serial clock is slow enough that each of its high and low phases spans several system clocks. Under that assumption every edge is seen exactly once after synchronisation. They also assume that select changes only while the serial clock is low. The bench drives a serial clock whose half period is eight system clocks. It changes the serial input and select only in the low phase, and it samples the serial output just before each rising edge. A frame is aborted only by raising select with the clock low, which keeps the stimulus inside these assumptions.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
    localparam int HDR_W    = 8;
    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 16;
    localparam int ADDR_LSB = 3;
    localparam int RD_BIT   = 2;
    localparam int LONG_LEN = HDR_W + DATA_W;
    localparam int CNT_W    = $clog2(LONG_LEN + 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] shreg;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic              ctl_stb;
        logic [HDR_W-2:0]  ctl_cmd;
        logic              wr_stb;
        logic [DATA_W-1:0] wr_data;
    } rx_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] shreg;
        logic              active;
    } tx_state_t;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
    parameter int            W      = 3,
    parameter int            STAGES = 2,
    parameter logic [W-1:0]  RST_V  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic [W-1:0] dprev
);
    logic [W-1:0] pipe_q [STAGES+1];

    generate
        for (genvar i = 0; i <= STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe_q[0] <= RST_V;
                    else        pipe_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe_q[i] <= RST_V;
                    else        pipe_q[i] <= pipe_q[i-1];
                end
            end
        end
    endgenerate

    assign dout  = pipe_q[STAGES-1];
    assign dprev = pipe_q[STAGES];
endmodule

// File: rtl/spi_rx_frame.sv
module spi_rx_frame
    import spi_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              rise,
    input  logic              mosi_s,
    output logic [CNT_W-1:0]  cnt,
    output logic              rd,
    output logic [ADDR_W-1:0] addr,
    output logic              ctl_stb,
    output logic [HDR_W-2:0]  ctl_cmd,
    output logic              wr_stb,
    output logic [DATA_W-1:0] wr_data
);
    rx_state_t        st_d, st_q;
    logic [HDR_W-1:0] hdr;

    always_comb begin
        st_d         = st_q;
        st_d.ctl_stb = 1'b0;
        st_d.wr_stb  = 1'b0;
        hdr          = {st_q.shreg[HDR_W-2:0], mosi_s};
        if (!cs_act) begin
            st_d.cnt = '0;
        end else if (rise) begin
            st_d.shreg = {st_q.shreg[DATA_W-2:0], mosi_s};
            if (st_q.cnt == CNT_W'(HDR_W - 1)) begin
                if (hdr[HDR_W-1]) begin
                    st_d.ctl_stb = 1'b1;
                    st_d.ctl_cmd = hdr[HDR_W-2:0];
                    st_d.cnt     = '0;
                end else begin
                    st_d.addr = hdr[ADDR_LSB +: ADDR_W];
                    st_d.rd   = hdr[RD_BIT];
                    st_d.cnt  = st_q.cnt + 1'b1;
                end
            end else if (st_q.cnt == CNT_W'(LONG_LEN - 1)) begin
                if (!st_q.rd) begin
                    st_d.wr_stb  = 1'b1;
                    st_d.wr_data = {st_q.shreg[DATA_W-2:0], mosi_s};
                end
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt     = st_q.cnt;
    assign rd      = st_q.rd;
    assign addr    = st_q.addr;
    assign ctl_stb = st_q.ctl_stb;
    assign ctl_cmd = st_q.ctl_cmd;
    assign wr_stb  = st_q.wr_stb;
    assign wr_data = st_q.wr_data;
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift
    import spi_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              fall,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              rd,
    input  logic [DATA_W-1:0] rd_data,
    output logic              miso_data
);
    tx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!cs_act) begin
            st_d = '0;
        end else if (fall) begin
            if (rd && cnt == CNT_W'(HDR_W)) begin
                st_d.shreg  = rd_data;
                st_d.active = 1'b1;
            end else if (cnt == '0) begin
                st_d.active = 1'b0;
            end else if (st_q.active) begin
                st_d.shreg = {st_q.shreg[DATA_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign miso_data = st_q.active & st_q.shreg[DATA_W-1];
endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave
    import spi_cmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              mosi,
    output logic              miso_data,
    output logic              miso_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              ctl_stb,
    output logic [HDR_W-2:0]  ctl_cmd
);
    logic [2:0]       s_now, s_prev;
    logic             cs_act, sclk_rise, sclk_fall, mosi_s;
    logic [CNT_W-1:0] bit_cnt;
    logic             rd_frame;
    logic [ADDR_W-1:0] frame_addr;

    spi_in_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_V(3'b010)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .din({sclk, cs_n, mosi}),
        .dout(s_now), .dprev(s_prev)
    );

    assign cs_act    = ~s_now[1];
    assign mosi_s    = s_now[0];
    assign sclk_rise = cs_act &  s_now[2] & ~s_prev[2];
    assign sclk_fall = cs_act & ~s_now[2] &  s_prev[2];

    spi_rx_frame u_rx (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .rise(sclk_rise), .mosi_s(mosi_s),
        .cnt(bit_cnt), .rd(rd_frame), .addr(frame_addr),
        .ctl_stb(ctl_stb), .ctl_cmd(ctl_cmd),
        .wr_stb(wr_stb), .wr_data(wr_data)
    );

    spi_tx_shift u_tx (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .fall(sclk_fall),
        .cnt(bit_cnt), .rd(rd_frame), .rd_data(rd_data), .miso_data(miso_data)
    );

    assign miso_en = cs_act;
    assign rd_addr = frame_addr;
    assign wr_addr = frame_addr;
endmodule

// File: rtl/spi_cmd_slave_chk.sv
module spi_cmd_slave_chk
    import spi_cmd_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cs_act,
    input logic             sclk_fall,
    input logic [CNT_W-1:0] bit_cnt,
    input logic             miso_data,
    input logic             miso_en,
    input logic             wr_stb,
    input logic             ctl_stb
);
    p_idle_outputs_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (!miso_data && !wr_stb && !ctl_stb));
    p_ctl_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_stb |=> !ctl_stb);
    p_wr_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);
    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && ctl_stb));
    p_abort_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (bit_cnt == '0));
    p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt < CNT_W'(LONG_LEN));
    p_enable_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        miso_en == cs_act);
    p_miso_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && $past(cs_act) && $changed(miso_data)) |-> $past(sclk_fall));
endmodule

bind spi_cmd_slave spi_cmd_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sclk_fall(sclk_fall),
    .bit_cnt(bit_cnt), .miso_data(miso_data), .miso_en(miso_en),
    .wr_stb(wr_stb), .ctl_stb(ctl_stb)
);

// File: tb/tb_spi_cmd_slave.sv
module tb_spi_cmd_slave;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic        miso_data, miso_en, wr_stb, ctl_stb;
    logic [3:0]  rd_addr, wr_addr;
    logic [15:0] rd_data, wr_data;
    logic [6:0]  ctl_cmd;

    logic [15:0] mem [16];
    int          n_tests = 0, n_fail = 0;
    int          wr_cnt = 0, ctl_cnt = 0;
    logic [3:0]  last_waddr;
    logic [15:0] last_wdata;
    logic [6:0]  last_cmd;
    logic [23:0] rx;
    bit          done = 0;

    always #10 clk = ~clk;

    spi_cmd_slave dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .miso_data(miso_data), .miso_en(miso_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .ctl_stb(ctl_stb), .ctl_cmd(ctl_cmd)
    );

    assign rd_data = mem[rd_addr];

    always @(posedge clk) begin
        if (wr_stb) begin
            wr_cnt     <= wr_cnt + 1;
            last_waddr <= wr_addr;
            last_wdata <= wr_data;
            mem[wr_addr] <= wr_data;
        end
        if (ctl_stb) begin
            ctl_cnt  <= ctl_cnt + 1;
            last_cmd <= ctl_cmd;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel();
        cs_n = 1'b0;
        wait_clk(6);
    endtask

    task automatic desel();
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(8);
    endtask

    // shifts nbits of w out from bit 23 downward; rx collects MISO, sampled before each rise
    task automatic xfer(input int nbits, input logic [23:0] w);
        rx = '0;
        for (int i = 0; i < nbits; i++) begin
            mosi = w[23-i];
            wait_clk(HALF);
            rx[23-i] = miso_data;
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
        wait_clk(4);
    endtask

    task automatic t_reset();
        check("R1 miso_en", miso_en, 0);
        check("R1 miso_data", miso_data, 0);
        check("R1 strobes", {wr_stb, ctl_stb}, 0);
    endtask

    task automatic t_control();
        int c0 = ctl_cnt, w0 = wr_cnt;
        sel();
        check("R7 enable while selected", miso_en, 1);
        xfer(8, {8'hB5, 16'h0});
        check("R2 ctl count", ctl_cnt - c0, 1);
        check("R2 ctl cmd", last_cmd, 7'h35);
        check("R2 no write", wr_cnt - w0, 0);
        desel();
        check("R7 released", miso_en, 0);
    endtask

    task automatic t_write();
        int w0 = wr_cnt;
        sel();
        xfer(24, {8'h2B, 16'hA5C3});   // addr 5, write, reserved bits set
        check("R3 wr count", wr_cnt - w0, 1);
        check("R3 wr addr", last_waddr, 5);
        check("R3 wr data", last_wdata, 16'hA5C3);
        check("R8 miso zero in write", rx, 0);
        desel();
    endtask

    task automatic t_read();
        int w0 = wr_cnt;
        sel();
        xfer(24, {8'h2C, 16'h0});      // addr 5, read
        check("R4 rd addr", rd_addr, 5);
        check("R4 read data", rx[15:0], 16'hA5C3);
        check("R8 header phase zero", rx[23:16], 0);
        check("R4 no write", wr_cnt - w0, 0);
        desel();
    endtask

    task automatic t_back_to_back();
        int w0 = wr_cnt, c0 = ctl_cnt;
        sel();
        xfer(24, {8'h78, 16'h1234});   // addr 15 write
        check("R5 write 1", last_wdata, 16'h1234);
        xfer(8, {8'hFF, 16'h0});
        check("R5 ctl cmd", last_cmd, 7'h7F);
        xfer(24, {8'h7C, 16'h0});      // addr 15 read
        check("R5 read 15", rx[15:0], 16'h1234);
        xfer(24, {8'h2C, 16'h0});      // addr 5 read
        check("R5 read 5", rx[15:0], 16'hA5C3);
        xfer(24, {8'h00, 16'h8001});   // addr 0 write
        check("R5 wr count", wr_cnt - w0, 2);
        check("R5 ctl count", ctl_cnt - c0, 1);
        check("R5 last addr", last_waddr, 0);
        desel();
    endtask

    task automatic t_abort();
        int w0 = wr_cnt, c0 = ctl_cnt;
        sel();
        xfer(12, {8'h18, 16'hFFFF});   // addr 3 write, cut short
        desel();
        check("R6 no write on abort", wr_cnt - w0, 0);
        sel();
        xfer(5, {8'h80, 16'h0});
        desel();
        check("R6 no ctl on abort", ctl_cnt - c0, 0);
        sel();
        xfer(24, {8'h18, 16'h0F0F});
        check("R6 restart write", last_wdata, 16'h0F0F);
        check("R6 restart addr", last_waddr, 3);
        xfer(24, {8'h1C, 16'h0});
        check("R6 readback", rx[15:0], 16'h0F0F);
        desel();
    endtask

    task automatic t_read_abort();
        sel();
        xfer(12, {8'h1C, 16'h0});
        desel();
        check("R8 released after abort", miso_data, 0);
        check("R7 enable low", miso_en, 0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = '0;
        wait_clk(3);
        t_reset();
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_control();
        t_write();
        t_read();
        t_back_to_back();
        t_abort();
        t_read_abort();
        done = 1;
    end

    initial begin
        fork
            wait (done == 1);
            begin
                repeat (200000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule